// File: doc/BRIEF.md
# Shifted Second-Operand Generator

This block produces the second operand of a 32-bit data-processing instruction, together with the carry-out of the shifter, ahead of the ALU. It receives the instruction word, the value of the register to be shifted (Rm), the low byte of the shift-amount register (Rs) and the current carry flag. When instruction bit 25 is set, the operand is an 8-bit constant rotated right by an even amount. When bit 25 is clear, Rm is shifted or rotated by either a 5-bit constant from the instruction or the byte from Rs. Register reads, the ALU and flag storage are outside the block.

The shifting logic is purely combinational. A parameter sets whether an output register follows it. The request and the result each travel on a valid/ready channel. With the register present, a request is accepted when `in_valid` and `in_ready` are both high at a clock edge, and its result appears on the next cycle. The result stays on the output pins, unchanged, until `out_ready` is high at an edge. `in_ready` equals `!out_valid || out_ready`, so a stalled result stops new requests from entering. Without the register, the channel passes straight through: `out_valid = in_valid`, `in_ready = out_ready`. A sender must hold its request steady until it is accepted.

Top module: `opnd_shifter`

## Requirements
- R1: When `in_instr[25]` is 1, the operand is `in_instr[7:0]` zero-extended and rotated right by twice `in_instr[11:8]`.
- R2: In the constant form, a rotate field of 0 makes carry-out equal to `in_carry`. Any other rotate value makes carry-out equal to bit 31 of the operand.
- R3: When `in_instr[25]` is 0, `in_instr[6:5]` picks the shift kind: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. `in_instr[4]` = 0 takes the amount from `in_instr[11:7]`, and 1 takes it from `in_rs_lo`. For an amount n from 1 to 31, the result is the plain shift or rotate, and carry-out is the last bit shifted out (Rm bit 32-n for a left shift, Rm bit n-1 otherwise).
- R4: A logical left shift by a constant amount of 0 returns Rm unchanged, with carry-out equal to `in_carry`.
- R5: A logical right or arithmetic right shift by a constant amount of 0 acts as a shift by 32. Logical right gives 0, and arithmetic right gives every bit equal to Rm bit 31. Carry-out is Rm bit 31 in both cases.
- R6: A rotate right by a constant amount of 0 rotates one place through the carry. The result is `{in_carry, Rm[31:1]}` and carry-out is Rm bit 0.
- R7: When the amount comes from `in_rs_lo` and is 0, every shift kind returns Rm unchanged, with carry-out equal to `in_carry`.
- R8: Logical shifts by a register amount of exactly 32 give 0. Carry-out is Rm bit 0 for a left shift and Rm bit 31 for a right shift. Register amounts above 32 give 0 with carry-out 0.
- R9: An arithmetic right shift by a register amount of 32 or more gives every bit equal to Rm bit 31, with carry-out equal to Rm bit 31.
- R10: A rotate by a register amount uses only the low 5 bits of that amount. If those 5 bits are 0 but the byte is nonzero, the result is Rm and carry-out is Rm bit 31.
- R11: With the output register present, each accepted request yields its result one cycle later. While `out_valid` is high and `out_ready` is low, `out_operand` and `out_carry` hold steady. `in_ready` is `!out_valid || out_ready`.
- R12: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_instr | input | 32 | Instruction word |
| in_rm | input | 32 | Value of the register to shift |
| in_rs_lo | input | 8 | Low byte of the shift-amount register |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_operand | output | 32 | Shifted or rotated operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Directed vectors cover each encoding whose zero or oversized amount changes meaning. These are a constant amount of zero for each of the four kinds, and register amounts of 0, 32, above 32 and nonzero multiples of 32. Each one shows whether the block treats that amount as a plain shift or as its special case. Constant-form vectors with a zero and a nonzero rotate separate the pass-through carry from the bit-31 carry. Random words, with amount bytes biased towards 0, 1, 31, 32, 33 and 255, are sent under random back-pressure. This tests the shifter against a bit-by-bit model and shows that a stalled result neither changes nor gets lost.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opnd_imm_rot.sv
module opnd_imm_rot #(
  parameter int DW    = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             carry_in,
  output logic [DW-1:0]    res,
  output logic             c_out
);
  localparam int SH_W = $clog2(DW);

  logic [DW-1:0]   ext;
  logic [2*DW-1:0] dbl;
  logic [SH_W-1:0] amt;

  assign ext   = {{(DW-IMM_W){1'b0}}, imm};
  assign amt   = SH_W'({rot, 1'b0});
  assign dbl   = {ext, ext} >> amt;
  assign res   = dbl[DW-1:0];
  assign c_out = (rot == '0) ? carry_in : dbl[DW-1];
endmodule

// File: rtl/opnd_reg_shift.sv
module opnd_reg_shift
  import opnd_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic [DW-1:0]         rm,
  input  logic [AW-1:0]         rs_amt,
  input  logic [$clog2(DW)-1:0] imm_amt,
  input  logic [2:0]            code,
  input  logic                  carry_in,
  output logic [DW-1:0]         res,
  output logic                  c_out
);
  localparam int SH_W = $clog2(DW);
  localparam logic [AW-1:0] FULL = AW'(DW);

  shift_kind_e kind;
  logic        by_reg;
  logic        rrx;
  logic [AW-1:0] amt;
  logic [AW-1:0] sat;

  logic [2*DW:0]      lwide;
  logic [DW:0]        rwide;
  logic signed [DW:0] awide;
  logic [2*DW-1:0]    owide;

  assign kind   = shift_kind_e'(code[2:1]);
  assign by_reg = code[0];

  // Map the constant-amount zero encodings onto amounts the core understands.
  always_comb begin
    rrx = 1'b0;
    amt = by_reg ? rs_amt : AW'(imm_amt);
    if (!by_reg && imm_amt == '0) begin
      case (kind)
        SK_LSL:  amt = '0;
        SK_LSR,
        SK_ASR:  amt = FULL;
        default: rrx = 1'b1;
      endcase
    end
  end

  assign sat   = (amt >= FULL) ? FULL : amt;
  assign lwide = {{(DW+1){1'b0}}, rm} << sat;
  assign rwide = {rm, 1'b0} >> sat;
  assign awide = $signed({rm, 1'b0}) >>> sat;
  assign owide = {rm, rm} >> amt[SH_W-1:0];

  always_comb begin
    res   = rm;
    c_out = carry_in;
    if (rrx) begin
      res   = {carry_in, rm[DW-1:1]};
      c_out = rm[0];
    end else if (amt != '0) begin
      case (kind)
        SK_LSL: begin
          res   = (amt > FULL) ? '0 : lwide[DW-1:0];
          c_out = (amt > FULL) ? 1'b0 : lwide[DW];
        end
        SK_LSR: begin
          res   = (amt > FULL) ? '0 : rwide[DW:1];
          c_out = (amt > FULL) ? 1'b0 : rwide[0];
        end
        SK_ASR: begin
          res   = awide[DW:1];
          c_out = awide[0];
        end
        default: begin
          res   = owide[DW-1:0];
          c_out = owide[DW-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd_out_stage.sv
module opnd_out_stage #(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_op,
  input  logic          in_c,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_op,
  output logic          out_c
);
  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q;
      logic [DW-1:0] op_q;
      logic          c_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_op    = op_q;
      assign out_c     = c_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vld_q <= 1'b0;
        else if (in_ready) vld_q <= in_valid;
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
          op_q <= in_op;
          c_q  <= in_c;
        end
      end

      // R11
      hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_c)));
    end else begin : g_pass
      wire unused_clk = clk ^ rst_n;
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_op    = in_op;
      assign out_c     = in_c;
    end
  endgenerate
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_pkg::*;
#(
  parameter int DW      = 32,
  parameter int RS_W    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_instr,
  input  logic [DW-1:0]   in_rm,
  input  logic [RS_W-1:0] in_rs_lo,
  input  logic            in_carry,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_operand,
  output logic            out_carry
);
  localparam int SH_W     = $clog2(DW);
  localparam int FORM_BIT = 25;
  localparam int IMM_W    = 8;
  localparam int ROT_W    = 4;
  localparam int AMT_LSB  = 7;

  logic          imm_form;
  logic [DW-1:0] imm_res, reg_res, op_comb;
  logic          imm_c, reg_c, c_comb;

  wire unused_instr = ^{in_instr[DW-1:FORM_BIT+1], in_instr[FORM_BIT-1:12]};

  assign imm_form = in_instr[FORM_BIT];

  opnd_imm_rot #(.DW(DW), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm      (in_instr[IMM_W-1:0]),
    .rot      (in_instr[IMM_W+ROT_W-1:IMM_W]),
    .carry_in (in_carry),
    .res      (imm_res),
    .c_out    (imm_c)
  );

  opnd_reg_shift #(.DW(DW), .AW(RS_W)) u_reg (
    .rm       (in_rm),
    .rs_amt   (in_rs_lo),
    .imm_amt  (in_instr[AMT_LSB+SH_W-1:AMT_LSB]),
    .code     (in_instr[6:4]),
    .carry_in (in_carry),
    .res      (reg_res),
    .c_out    (reg_c)
  );

  assign op_comb = imm_form ? imm_res : reg_res;
  assign c_comb  = imm_form ? imm_c   : reg_c;

  opnd_out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (op_comb),
    .in_c      (c_comb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_op    (out_operand),
    .out_c     (out_carry)
  );

  // R2
  imm_zero_rot_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm_form && in_instr[11:8] == '0) |-> (c_comb == in_carry));

  // R7
  reg_zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_form && in_instr[4] && in_rs_lo == '0)
      |-> (op_comb == in_rm && c_comb == in_carry));

  // R8
  logical_overshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_form && in_instr[4] && !in_instr[6] && in_rs_lo > RS_W'(DW))
      |-> (op_comb == '0 && !c_comb));

  // R9
  asr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_form && in_instr[6:4] == 3'b101 && in_rs_lo >= RS_W'(DW))
      |-> (op_comb == {DW{in_rm[DW-1]}} && c_comb == in_rm[DW-1]));

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rm = '0;
  logic [7:0]  in_rs_lo = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_operand;
  logic        out_carry;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  opnd_shifter u_opnd_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rm(in_rm), .in_rs_lo(in_rs_lo), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_operand(out_operand), .out_carry(out_carry)
  );

  // Behavioural model: one bit position per loop step.
  function automatic logic [32:0] model(logic [31:0] ins, logic [31:0] rm,
                                        logic [7:0] rs, logic cin);
    logic [31:0] v;
    logic c;
    int n;
    c = cin;
    if (ins[25]) begin
      v = {24'd0, ins[7:0]};
      for (int k = 0; k < 2 * int'(ins[11:8]); k++) v = {v[0], v[31:1]};
      if (ins[11:8] != 0) c = v[31];
      return {c, v};
    end
    n = ins[4] ? int'(rs) : int'(ins[11:7]);
    v = rm;
    if (!ins[4] && n == 0) begin
      case (ins[6:5])
        2'd0: return {cin, rm};
        2'd1: return {rm[31], 32'd0};
        2'd2: return {rm[31], {32{rm[31]}}};
        default: return {rm[0], cin, rm[31:1]};
      endcase
    end
    if (ins[6:5] == 2'd3) begin
      if (n != 0 && n % 32 == 0) c = rm[31];
      for (int k = 0; k < n % 32; k++) begin c = v[0]; v = {v[0], v[31:1]}; end
      return {c, v};
    end
    for (int k = 0; k < n; k++) begin
      case (ins[6:5])
        2'd0: begin c = v[31]; v = v << 1; end
        2'd1: begin c = v[0];  v = v >> 1; end
        default: begin c = v[0]; v = {v[31], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic check(bit ok, string req, logic [32:0] act, logic [32:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual c=%0b op=%08h expected c=%0b op=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // Per-cycle compare; called #1 after each falling edge.
  task automatic observe();
    check(out_valid == (exp_q.size() != 0), "R11 valid",
          {32'd0, out_valid}, {32'd0, exp_q.size() != 0});
    if (out_valid && exp_q.size() != 0) begin
      check({out_carry, out_operand} === exp_q[0], tag_q[0],
            {out_carry, out_operand}, exp_q[0]);
      if (out_ready) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
    check(in_ready == (!out_valid || out_ready), "R11 ready",
          {32'd0, in_ready}, {32'd0, !out_valid || out_ready});
    if (in_valid && in_ready) begin
      exp_q.push_back(model(in_instr, in_rm, in_rs_lo, in_carry));
      tag_q.push_back(tag_q.size() >= 0 ? cur_tag : cur_tag);
    end
  endtask

  string cur_tag = "";

  task automatic send(logic [31:0] ins, logic [31:0] rm, logic [7:0] rs,
                      logic cin, string tag, bit stall);
    bit acc;
    do begin
      @(negedge clk);
      in_valid = 1'b1; in_instr = ins; in_rm = rm; in_rs_lo = rs; in_carry = cin;
      cur_tag = tag;
      out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      acc = in_ready;
      observe();
    end while (!acc);
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = (i % 3 != 0) || (i >= cycles - 4);
      #1;
      observe();
    end
  endtask

  function automatic logic [31:0] imm_ins(logic [3:0] rot, logic [7:0] imm);
    return {4'hE, 3'b001, 4'hD, 1'b0, 8'h00, rot, imm};
  endfunction

  function automatic logic [31:0] reg_ins(logic [4:0] amt, logic [1:0] kind, logic by_reg);
    return {4'hE, 3'b000, 4'hD, 1'b0, 8'h00, amt, kind, by_reg, 4'h2};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R12: reset holds the output idle
    check(out_valid == 1'b0, "R12", {32'd0, out_valid}, 33'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R12", {32'd0, out_valid}, 33'd0);

    send(imm_ins(4'd4, 8'hFF), 32'h0, 8'h0, 1'b0, "R1 rot8", 0);
    send(imm_ins(4'd1, 8'h03), 32'h0, 8'h0, 1'b0, "R1 rot2", 0);
    send(imm_ins(4'd0, 8'h3F), 32'h0, 8'h0, 1'b1, "R2 rot0", 0);
    send(imm_ins(4'd15, 8'h81), 32'h0, 8'h0, 1'b1, "R2 rot30", 0);
    send(reg_ins(5'd4, 2'd0, 1'b0), 32'h8000000F, 8'h0, 1'b0, "R3 lsl4", 0);
    send(reg_ins(5'd0, 2'd1, 1'b1), 32'h00001180, 8'd8, 1'b0, "R3 lsr8", 0);
    send(reg_ins(5'd3, 2'd2, 1'b0), 32'h8000000C, 8'h0, 1'b0, "R3 asr3", 0);
    send(reg_ins(5'd0, 2'd3, 1'b1), 32'h00000801, 8'd12, 1'b0, "R3 ror12", 0);
    send(reg_ins(5'd0, 2'd0, 1'b0), 32'hFFFFFFFF, 8'h0, 1'b0, "R4", 0);
    send(reg_ins(5'd0, 2'd1, 1'b0), 32'h80000001, 8'h0, 1'b0, "R5 lsr", 0);
    send(reg_ins(5'd0, 2'd2, 1'b0), 32'h80000000, 8'h0, 1'b0, "R5 asr neg", 0);
    send(reg_ins(5'd0, 2'd2, 1'b0), 32'h7FFFFFFF, 8'h0, 1'b1, "R5 asr pos", 0);
    send(reg_ins(5'd0, 2'd3, 1'b0), 32'h00000002, 8'h0, 1'b1, "R6", 0);
    for (int k = 0; k < 4; k++)
      send(reg_ins(5'd9, 2'(k), 1'b1), 32'hC3A5_0F1E, 8'd0, 1'b1, "R7", 0);
    send(reg_ins(5'd0, 2'd0, 1'b1), 32'h00000001, 8'd32, 1'b0, "R8 lsl32", 0);
    send(reg_ins(5'd0, 2'd1, 1'b1), 32'h80000000, 8'd32, 1'b0, "R8 lsr32", 0);
    send(reg_ins(5'd0, 2'd0, 1'b1), 32'hFFFFFFFF, 8'd33, 1'b1, "R8 lsl33", 0);
    send(reg_ins(5'd0, 2'd1, 1'b1), 32'hFFFFFFFF, 8'd200, 1'b1, "R8 lsr200", 0);
    send(reg_ins(5'd0, 2'd2, 1'b1), 32'h80000000, 8'd32, 1'b0, "R9 asr32", 0);
    send(reg_ins(5'd0, 2'd2, 1'b1), 32'h40000000, 8'd255, 1'b1, "R9 asr255", 0);
    send(reg_ins(5'd0, 2'd3, 1'b1), 32'h12345678, 8'd32, 1'b0, "R10 ror32", 0);
    send(reg_ins(5'd0, 2'd3, 1'b1), 32'h92345678, 8'd64, 1'b0, "R10 ror64", 0);
    send(reg_ins(5'd0, 2'd3, 1'b1), 32'h0000000F, 8'd36, 1'b0, "R10 ror36", 0);
    idle(4);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] rs;
      logic [31:0] ins;
      case ($urandom_range(0, 7))
        0: rs = 8'd0;
        1: rs = 8'd1;
        2: rs = 8'd31;
        3: rs = 8'd32;
        4: rs = 8'd33;
        5: rs = 8'd255;
        default: rs = 8'($urandom);
      endcase
      ins = $urandom;
      send(ins, $urandom, rs, 1'($urandom), ins[25] ? "R1 rand" : "R3 rand", 1);
    end
    idle(12);
    check(exp_q.size() == 0, "R11 drain", {1'b0, 32'(exp_q.size())}, 33'd0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule